// File: doc/BRIEF.md
# Gray-Code Ring Time-to-Digital Converter

This block measures, in whole clock ticks, the interval between a start pulse and a later stop pulse. It produces an unsigned binary result. Each bit of the result has its own ring of one-bit stages, and each ring is built as an inverted-feedback shift ring (Johnson style). While a measurement runs, every ring moves one stage per clock. The last stage of each ring therefore traces one bit of a Gray-coded tick count.

When no measurement runs, every ring holds a preset pattern. The preset sets the phase of that ring so that the ring tap reads 0 at the start.

On stop, one flip-flop per bit takes the ring taps. A combinational chain then turns the captured Gray word into binary.

Ring sizes for an `NBITS`-bit converter:

- Bit k below the MSB uses a ring of 2^(k+1) stages, preset with its lowest 2^k stages set.
- The MSB uses a ring of 2^(NBITS-1) stages, preset to all zeros.
- The default 6-bit case therefore holds rings of 2, 4, 8, 16, 32 and 32 stages.

The caller pulses `start` and later pulses `stop`. The result appears together with a one-cycle `valid` strobe. Intervals too long for the output width saturate and raise `overflow`.

Top module: `gray_ring_tdc`

## Requirements
- R1: After reset the outputs read `count` = 0, `valid` = 0 and `overflow` = 0.
- R2: When `start` is sampled high at an idle clock edge and `stop` is sampled high d edges later (1 <= d <= 2^NBITS-1), the result is `count` = d with `overflow` = 0.
- R3: When d >= 2^NBITS, `count` saturates at 2^NBITS-1 (all ones) and `overflow` reads 1.
- R4: `valid` is high for exactly the one cycle that follows the edge where `stop` ends a measurement. `count` and `overflow` change only at such an edge and hold their value until the next result.
- R5: A `stop` sampled while no measurement runs has no effect. This includes a `stop` sampled in the same cycle as the `start` that begins a measurement. No result is produced and the earlier `count` is kept.
- R6: A `start` sampled while a measurement runs is ignored. The running measurement still reports its full interval from the first `start`.
- R7: Every tick of a running measurement changes exactly one captured ring tap. So intervals d and d+1 give results that differ by exactly one.
- R8: Once a result is produced the converter is idle at once. A `start` sampled at the very next edge begins a new, correct measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock; one period is one resolution step |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins a measurement when sampled high while idle |
| stop | input | 1 | Ends a running measurement when sampled high |
| count | output | NBITS | Binary interval in ticks, saturated |
| valid | output | 1 | One-cycle strobe marking a new result |
| overflow | output | 1 | Interval reached 2^NBITS ticks or more |

## Verification
A ring that shifts in the wrong direction, holds a wrong preset or gets the wrong length shows up as a wrong `count` on the first measurement whose length passes the ring's first toggle point. The 2-stage ring fails within one or two ticks. The MSB ring fails only at about half scale. So a sweep of every length from 1 to 2^NBITS-1 exposes every ring.

A wrong control state shows up sooner. Examples are a measurement that never closes, a stray result, or a result that is not reset. These appear at the next edge as a missing, repeated or extra `valid`, or as a `count` that moves without a result.

Wrap detection is seen only at the boundary between 2^NBITS-1 and 2^NBITS, where the result either saturates or folds back to a small value.

// File: rtl/gtdc_pkg.sv
package gtdc_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } gtdc_state_e;

  // Stage count of the ring that produces Gray bit k of an n-bit result.
  function automatic int ring_len(int k, int n);
    return (k == n - 1) ? (1 << (n - 1)) : (1 << (k + 1));
  endfunction

  // Number of leading stages preset to one, which fixes the ring's phase.
  function automatic int ring_ones(int k, int n);
    return (k == n - 1) ? 0 : (1 << k);
  endfunction

endpackage

// File: rtl/gtdc_ring.sv
module gtdc_ring #(
  parameter int LEN  = 4,
  parameter int ONES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic reload,
  output logic tap
);

  localparam logic [LEN-1:0] PRESET = {LEN{1'b1}} >> (LEN - ONES);

  logic [LEN-1:0] stage_q;
  logic [LEN-1:0] stage_d;

  // Stage 0 takes the inverted last stage; every other stage copies its left neighbour.
  always_comb begin
    stage_d = stage_q;
    if (reload) begin
      stage_d = PRESET;
    end else if (adv) begin
      stage_d = {stage_q[LEN-2:0], ~stage_q[LEN-1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= PRESET;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign tap = stage_q[LEN-1];

endmodule

// File: rtl/gtdc_ctrl.sv
module gtdc_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic at_top,
  output logic adv,
  output logic capture,
  output logic busy,
  output logic wrapped
);
  import gtdc_pkg::*;

  gtdc_state_e state_q;
  gtdc_state_e state_d;
  logic        wrap_q;
  logic        wrap_d;
  logic        start_ok;
  logic        stop_ok;

  assign start_ok = start && (state_q == ST_IDLE);
  assign stop_ok  = stop && (state_q == ST_RUN);

  // The rings move on the accepting start edge and on every running edge except the stop edge.
  assign adv     = start_ok || ((state_q == ST_RUN) && !stop);
  assign capture = stop_ok;

  always_comb begin
    state_d = state_q;
    if (start_ok) begin
      state_d = ST_RUN;
    end else if (stop_ok) begin
      state_d = ST_IDLE;
    end
  end

  // Sticky wrap: set when the Gray word leaves its last code while advancing.
  always_comb begin
    wrap_d = wrap_q;
    if (start_ok) begin
      wrap_d = 1'b0;
    end else if (adv && at_top) begin
      wrap_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wrap_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wrap_q  <= wrap_d;
    end
  end

  assign busy    = (state_q == ST_RUN);
  assign wrapped = wrap_q;

endmodule

// File: rtl/gtdc_gray2bin.sv
module gtdc_gray2bin #(
  parameter int W = 6
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);

  // Each binary bit is the parity of the Gray bits at and above it.
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int k = W - 1; k >= 0; k--) begin
      acc    = acc ^ gray[k];
      bin[k] = acc;
    end
  end

endmodule

// File: rtl/gray_ring_tdc.sv
module gray_ring_tdc #(
  parameter int NBITS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  output logic [NBITS-1:0] count,
  output logic             valid,
  output logic             overflow
);
  import gtdc_pkg::*;

  localparam logic [NBITS-1:0] TOP_GRAY = NBITS'(1) << (NBITS - 1);

  logic             rst_meta;
  logic             rst_ok;
  logic [NBITS-1:0] taps;
  logic             adv;
  logic             capture;
  logic             busy;
  logic             wrapped;
  logic [NBITS-1:0] gray_q;
  logic [NBITS-1:0] gray_d;
  logic             ovf_q;
  logic             ovf_d;
  logic             valid_q;
  logic [NBITS-1:0] bin;

  // Reset asserts at once and releases on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  gtdc_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_ok),
    .start   (start),
    .stop    (stop),
    .at_top  (taps == TOP_GRAY),
    .adv     (adv),
    .capture (capture),
    .busy    (busy),
    .wrapped (wrapped)
  );

  for (genvar k = 0; k < NBITS; k++) begin : g_ring
    gtdc_ring #(
      .LEN  (ring_len(k, NBITS)),
      .ONES (ring_ones(k, NBITS))
    ) u_ring (
      .clk    (clk),
      .rst_n  (rst_ok),
      .adv    (adv),
      .reload (capture),
      .tap    (taps[k])
    );
  end

  // One capture flip-flop per result bit, enabled only by an accepted stop.
  always_comb begin
    gray_d = gray_q;
    ovf_d  = ovf_q;
    if (capture) begin
      gray_d = taps;
      ovf_d  = wrapped;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      gray_q  <= '0;
      ovf_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      gray_q  <= gray_d;
      ovf_q   <= ovf_d;
      valid_q <= capture;
    end
  end

  gtdc_gray2bin #(.W(NBITS)) u_dec (
    .gray (gray_q),
    .bin  (bin)
  );

  assign count    = ovf_q ? {NBITS{1'b1}} : bin;
  assign valid    = valid_q;
  assign overflow = ovf_q;

endmodule

// File: rtl/gtdc_checker.sv
module gtdc_checker #(
  parameter int N = 6
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         start,
  input logic         stop,
  input logic         busy,
  input logic         adv,
  input logic [N-1:0] taps,
  input logic [N-1:0] count,
  input logic         valid,
  input logic         overflow
);

  // R4: the result strobe never lasts two cycles
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_ok)
    valid |=> !valid);

  // R4: a strobe only follows a stop taken while running
  a_r4_after_stop: assert property (@(posedge clk) disable iff (!rst_ok)
    valid |-> ($past(stop) && $past(busy)));

  // R4: result outputs move only at an accepted stop
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    !($past(stop) && $past(busy)) |-> ($stable(count) && $stable(overflow)));

  // R5: a stop seen while idle gives no result
  a_r5_idle_stop: assert property (@(posedge clk) disable iff (!rst_ok)
    (!busy && stop) |=> !valid);

  // R6: a repeated start does not end a running measurement
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_ok)
    (busy && start && !stop) |=> busy);

  // R7: each advance flips exactly one ring tap
  a_r7_one_bit_step: assert property (@(posedge clk) disable iff (!rst_ok)
    adv |=> ($countones(taps ^ $past(taps)) == 1));

  // R8: idle rings sit at the zero code, ready for the next start
  a_r8_idle_preset: assert property (@(posedge clk) disable iff (!rst_ok)
    !busy |-> (taps == '0));

endmodule

bind gray_ring_tdc gtdc_checker #(.N(NBITS)) u_chk (
  .clk      (clk),
  .rst_ok   (rst_ok),
  .start    (start),
  .stop     (stop),
  .busy     (busy),
  .adv      (adv),
  .taps     (taps),
  .count    (count),
  .valid    (valid),
  .overflow (overflow)
);

// File: tb/gray_ring_tdc_test.sv
module gray_ring_tdc_test;

  localparam int N    = 6;
  localparam int FULL = (1 << N) - 1;

  typedef struct {
    int cnt;
    bit ovf;
    bit step;
    string req;
  } exp_t;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         stop;
  logic [N-1:0] count;
  logic         valid;
  logic         overflow;

  int   checks;
  int   errors;
  exp_t expq[$];
  bit   done;

  gray_ring_tdc #(.NBITS(N)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .stop     (stop),
    .count    (count),
    .valid    (valid),
    .overflow (overflow)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: start sampled at edge E0, stop at edge Ed; xtra>0 pulses start again at edge E(xtra).
  task automatic measure(input int d, input int xtra, input bit stop_with_start,
                         input int gap, input bit step, input string req);
    exp_t e;
    e.cnt  = (d > FULL) ? FULL : d;
    e.ovf  = (d > FULL);
    e.step = step;
    e.req  = req;
    expq.push_back(e);
    start = 1'b1;
    stop  = stop_with_start;
    for (int i = 1; i <= d; i++) begin
      @(negedge clk);
      start = (i == xtra);
      stop  = (i == d);
    end
    @(negedge clk);
    start = 1'b0;
    stop  = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // Monitor: pops an expected item for each strobe and compares it.
  initial begin
    int  last_cnt;
    bit  was_valid;
    last_cnt  = 0;
    was_valid = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && valid) begin
        check(!was_valid, "R4 strobe length", 2, 1);
        if (expq.size() == 0) begin
          check(1'b0, "R5 unexpected result", int'(count), -1);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(int'(count) == e.cnt, {e.req, " count"}, int'(count), e.cnt);
          check(overflow == e.ovf, {e.req, " overflow"}, int'(overflow), int'(e.ovf));
          if (e.step) begin
            check(int'(count) - last_cnt == 1, "R7 unit step", int'(count) - last_cnt, 1);
          end
        end
        last_cnt = int'(count);
      end
      was_valid = valid;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int held;
    done   = 1'b0;
    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    start  = 1'b0;
    stop   = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(count == '0, "R1 count", int'(count), 0);
    check(valid == 1'b0, "R1 valid", int'(valid), 0);
    check(overflow == 1'b0, "R1 overflow", int'(overflow), 0);

    // R2 and R7: every in-range interval, ascending
    for (int d = 1; d <= FULL; d++) begin
      measure(d, 0, 1'b0, 2, (d > 1), "R2");
    end

    // R3: saturation at and beyond full scale
    measure(FULL + 1, 0, 1'b0, 2, 1'b0, "R3");
    measure(FULL + 2, 0, 1'b0, 2, 1'b0, "R3");
    measure(100, 0, 1'b0, 2, 1'b0, "R3");
    measure(FULL, 0, 1'b0, 2, 1'b0, "R3 edge");

    // R5: lone stop while idle
    @(negedge clk);
    held = int'(count);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check(valid == 1'b0, "R5 idle stop valid", int'(valid), 0);
    check(int'(count) == held, "R5 idle stop count", int'(count), held);
    repeat (2) @(negedge clk);

    // R5: stop together with the accepted start is ignored
    measure(15, 0, 1'b1, 2, 1'b0, "R5");

    // R6: second start mid-measurement
    measure(20, 7, 1'b0, 2, 1'b0, "R6");
    measure(9, 9, 1'b0, 2, 1'b0, "R6");

    // R8: back-to-back measurements with no idle gap
    measure(5, 0, 1'b0, 0, 1'b0, "R8");
    measure(9, 0, 1'b0, 0, 1'b0, "R8");
    measure(1, 0, 1'b0, 0, 1'b0, "R8");
    measure(3, 0, 1'b0, 3, 1'b0, "R8");

    // R4: result holds while idle
    held = int'(count);
    repeat (5) @(negedge clk);
    check(int'(count) == held, "R4 hold count", int'(count), held);
    check(valid == 1'b0, "R4 hold valid", int'(valid), 0);
    check(expq.size() == 0, "R4 results outstanding", expq.size(), 0);

    done = 1'b1;
    finish_run();
  end

endmodule